// File: doc/BRIEF.md
# Hot-Plug Slot Event Register Bank

This block keeps the per-slot status, event latches and mask bits for a hot-plug slot controller. It also holds a controller-level enable register and builds an interrupt locator word. Each slot has one 32-bit word. That word reports live levels from the slot hardware: presence, latch sensor, attention button, fault lines and the 66 MHz capability strap. It also reports the slot state and the two indicator states that a command engine last wrote. Next to these sit five edge-detected event flags, five interrupt masks and two error-reporting masks. Software reads a flag and clears it by writing a one to that bit. Because of this, writing back a word just read clears every event that was pending in it.

Software reaches the bank through a plain single-cycle register port. Read data is combinational from the address. A write takes effect at the clock edge on which the write strobe is high. Address 0 holds the locator, address 1 the controller register, and address 2+i the word of slot i. The command engine sends slot-state and indicator updates over a valid/ready port. Ready is held high, so a beat is taken on every cycle in which valid is high and there is never back-pressure. The block drives two outputs: an interrupt request, and an error request built from the unmasked error sources.

Top module: `hp_slot_evt_bank`

## Requirements
- R1: After reset every slot word reads state 3, power indicator 3 and attention indicator 3 (bits 5:0 = 0x3F). All seven mask bits (30:24) read 1 and all event flags read 0. The controller register reads 0x0000000F, and the interrupt and error outputs are low.
- R2: Slot status bits follow the hardware inputs two clocks after a change. Bit 6 reads 0 while either fault input of that slot is high. Bit 7 is the button level, bit 8 the latch-open level and bit 9 the 66 MHz strap. Bits 11:10 are the presence code, where 3 means empty.
- R3: Each event sets its flag and the flag stays set. A presence code change sets bit 16. A rising isolated fault sets bit 17 and a rising button sets bit 18. Any latch change sets bit 19, and a rising connected fault sets bit 20. A falling button or falling fault input sets no flag.
- R4: Writing 1 to a flag bit (slot bits 20:16, controller bits 17:16) clears it, and writing 0 leaves it unchanged. Writing back the value just read clears every pending slot flag. A slot write loads mask bits 30:24.
- R5: When a new event and a write-1 clear of the same flag happen in the same cycle, the flag stays set.
- R6: Reserved bits read as zero. These are slot bits 31, 23:21 and 15:12, and controller bits 31:18 and 15:4. Addresses above the last slot read zero.
- R7: Locator bit 0 is 1 when the command flag is set and the command interrupt mask (controller bit 2) is 0. Locator bit i+1 is 1 when slot i has a set flag whose interrupt mask bit (flag bit + 8) is 0.
- R8: The interrupt output is high exactly when the locator is nonzero and the global interrupt mask (controller bit 0) is 0.
- R9: The error output is high when the global error mask (controller bit 1) is 0 and at least one of these holds: the arbiter flag is set with controller bit 3 equal to 0; a slot latch-change flag is set with its bit 29 equal to 0; a slot connected-fault flag is set with its bit 30 equal to 0.
- R10: An accepted update beat writes the state, power indicator and attention indicator of the addressed slot. A field coded 0 leaves that field unchanged. Software writes never change these fields, and upd_ready is high out of reset.
- R11: A pulse on cmd_done sets controller bit 16, and a pulse on arb_fault sets controller bit 17, whatever the mask values.
- R12: Event detection stays off for the first three clocks after reset. Input levels present at reset, such as an empty slot with presence code 3, therefore latch no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 32 | Combinational read data |
| hw_prsnt | input | 2*N_SLOTS | Presence code per slot (2 bits each) |
| hw_latch_open | input | N_SLOTS | Latch sensor per slot, 1 = open |
| hw_button | input | N_SLOTS | Attention button level per slot |
| hw_iso_fault | input | N_SLOTS | Isolated power fault per slot |
| hw_conn_fault | input | N_SLOTS | Connected power fault per slot |
| hw_m66 | input | N_SLOTS | 66 MHz capability strap per slot |
| upd_valid | input | 1 | Command engine update beat valid |
| upd_ready | output | 1 | Update beat accepted |
| upd_slot | input | SLOT_W | Target slot index |
| upd_state | input | 2 | New slot state, 0 = keep |
| upd_pwr_ind | input | 2 | New power indicator code, 0 = keep |
| upd_attn_ind | input | 2 | New attention indicator code, 0 = keep |
| cmd_done | input | 1 | Command completion pulse |
| arb_fault | input | 1 | Arbiter error pulse |
| irq | output | 1 | Interrupt request |
| err_req | output | 1 | Error request |

## Verification
The hardest case to reach from the ports is a write-1 clear that lands on the same edge as a freshly detected event. The event appears three clocks after the pin moves, because it passes through two synchronizer stages and then the edge compare. The stimulus raises a button at a falling clock edge, counts two rising edges, and places the clearing write so that it is taken on the third edge. The flag must then still read 1. A second subtle case is the reset window: slots sit at presence code 3 during reset, and no presence-change flag may appear once detection turns on.

// File: rtl/hpse_pkg.sv
package hpse_pkg;
  // slot word field positions (software decodes these)
  localparam int ST_LO    = 0;
  localparam int PI_LO    = 2;
  localparam int AI_LO    = 4;
  localparam int PF_BIT   = 6;
  localparam int BTN_BIT  = 7;
  localparam int LAT_BIT  = 8;
  localparam int M66_BIT  = 9;
  localparam int PRS_LO   = 10;
  localparam int EVT_LO   = 16;
  localparam int IMSK_LO  = 24;
  localparam int EMSK_LO  = 29;
  localparam int NUM_EVT  = 5;
  localparam int NUM_EMSK = 2;

  // event flag order inside bits 20:16
  typedef enum int {EV_PRS = 0, EV_ISO = 1, EV_BTN = 2, EV_LAT = 3, EV_CPF = 4} evt_idx_e;

  // controller word positions
  localparam int C_GINT = 0;
  localparam int C_GERR = 1;
  localparam int C_CMDI = 2;
  localparam int C_ARBE = 3;
  localparam int C_CMDF = 16;
  localparam int C_ARBF = 17;

  // two-bit code meaning "leave unchanged" on the update port
  localparam logic [1:0] CODE_KEEP = 2'd0;
  localparam logic [1:0] CODE_RST  = 2'd3;

  typedef struct packed {
    logic [1:0] attn;
    logic [1:0] pwr;
    logic [1:0] st;
  } slot_ind_t;
endpackage

// File: rtl/hpse_sync.sv
module hpse_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/hpse_slot.sv
module hpse_slot
  import hpse_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        armed,
  input  logic [1:0]  hw_prsnt,
  input  logic        hw_latch,
  input  logic        hw_btn,
  input  logic        hw_iso,
  input  logic        hw_conn,
  input  logic        hw_m66,
  input  logic        wr_hit,
  input  logic [30:16] wdata,
  input  logic        upd_hit,
  input  slot_ind_t   upd_ind,
  output logic [31:0] rdata,
  output logic [NUM_EVT-1:0] evt_q,
  output logic        int_pend,
  output logic        err_pend
);
  localparam int RAW_W = 7;

  logic [RAW_W-1:0] raw, syn;
  logic [1:0] s_prs, p_prs;
  logic s_lat, s_btn, s_iso, s_conn, s_m66;
  logic p_lat, p_btn, p_iso, p_conn;
  logic [NUM_EVT-1:0]  evt_new, evt_clr, imask_q;
  logic [NUM_EMSK-1:0] emask_q;
  slot_ind_t ind_q;

  assign raw = {hw_prsnt, hw_latch, hw_btn, hw_iso, hw_conn, hw_m66};

  hpse_sync #(.W(RAW_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (syn)
  );

  assign {s_prs, s_lat, s_btn, s_iso, s_conn, s_m66} = syn;

  // previous synchronized levels for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_prs  <= '0;
      p_lat  <= 1'b0;
      p_btn  <= 1'b0;
      p_iso  <= 1'b0;
      p_conn <= 1'b0;
    end else begin
      p_prs  <= s_prs;
      p_lat  <= s_lat;
      p_btn  <= s_btn;
      p_iso  <= s_iso;
      p_conn <= s_conn;
    end
  end

  always_comb begin
    evt_new         = '0;
    evt_new[EV_PRS] = s_prs != p_prs;
    evt_new[EV_ISO] = s_iso & ~p_iso;
    evt_new[EV_BTN] = s_btn & ~p_btn;
    evt_new[EV_LAT] = s_lat ^ p_lat;
    evt_new[EV_CPF] = s_conn & ~p_conn;
    if (!armed) evt_new = '0;
  end

  assign evt_clr = wr_hit ? wdata[EVT_LO +: NUM_EVT] : '0;

  // flags: a fresh event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q   <= '0;
      imask_q <= '1;
      emask_q <= '1;
    end else begin
      evt_q <= (evt_q & ~evt_clr) | evt_new;
      if (wr_hit) begin
        imask_q <= wdata[IMSK_LO +: NUM_EVT];
        emask_q <= wdata[EMSK_LO +: NUM_EMSK];
      end
    end
  end

  // state and indicators owned by the command engine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ind_q <= '{attn: CODE_RST, pwr: CODE_RST, st: CODE_RST};
    end else if (upd_hit) begin
      if (upd_ind.st   != CODE_KEEP) ind_q.st   <= upd_ind.st;
      if (upd_ind.pwr  != CODE_KEEP) ind_q.pwr  <= upd_ind.pwr;
      if (upd_ind.attn != CODE_KEEP) ind_q.attn <= upd_ind.attn;
    end
  end

  always_comb begin
    rdata                            = '0;
    rdata[ST_LO +: 2]                = ind_q.st;
    rdata[PI_LO +: 2]                = ind_q.pwr;
    rdata[AI_LO +: 2]                = ind_q.attn;
    rdata[PF_BIT]                    = ~(s_iso | s_conn);
    rdata[BTN_BIT]                   = s_btn;
    rdata[LAT_BIT]                   = s_lat;
    rdata[M66_BIT]                   = s_m66;
    rdata[PRS_LO +: 2]               = s_prs;
    rdata[EVT_LO +: NUM_EVT]         = evt_q;
    rdata[IMSK_LO +: NUM_EVT]        = imask_q;
    rdata[EMSK_LO +: NUM_EMSK]       = emask_q;
  end

  assign int_pend = |(evt_q & ~imask_q);
  assign err_pend = (evt_q[EV_LAT] & ~emask_q[0]) | (evt_q[EV_CPF] & ~emask_q[1]);
endmodule

// File: rtl/hpse_ctrl.sv
module hpse_ctrl
  import hpse_pkg::*;
#(
  parameter int N_SLOTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [3:0]         wmask,
  input  logic [1:0]         wclr,
  input  logic               cmd_done,
  input  logic               arb_fault,
  input  logic [N_SLOTS-1:0] slot_int,
  input  logic [N_SLOTS-1:0] slot_err,
  output logic [N_SLOTS:0]   locator,
  output logic [31:0]        ctrl_rd,
  output logic               irq,
  output logic               err_req,
  output logic               gint_mask,
  output logic               gerr_mask
);
  logic [3:0] mask_q;
  logic cmd_f, arb_f;
  logic clr_cmd, clr_arb;

  assign clr_cmd = wr_hit & wclr[0];
  assign clr_arb = wr_hit & wclr[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      cmd_f  <= 1'b0;
      arb_f  <= 1'b0;
    end else begin
      if (wr_hit) mask_q <= wmask;
      cmd_f <= (cmd_f & ~clr_cmd) | cmd_done;
      arb_f <= (arb_f & ~clr_arb) | arb_fault;
    end
  end

  assign gint_mask = mask_q[C_GINT];
  assign gerr_mask = mask_q[C_GERR];
  assign locator   = {slot_int, cmd_f & ~mask_q[C_CMDI]};
  assign irq       = (|locator) & ~gint_mask;
  assign err_req   = ~gerr_mask & ((arb_f & ~mask_q[C_ARBE]) | (|slot_err));

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[3:0]     = mask_q;
    ctrl_rd[C_CMDF]  = cmd_f;
    ctrl_rd[C_ARBF]  = arb_f;
  end
endmodule

// File: rtl/hp_slot_evt_bank.sv
module hp_slot_evt_bank
  import hpse_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int ADDR_W  = 3,
  parameter int SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_wr,
  output logic [31:0]          reg_rdata,
  input  logic [2*N_SLOTS-1:0] hw_prsnt,
  input  logic [N_SLOTS-1:0]   hw_latch_open,
  input  logic [N_SLOTS-1:0]   hw_button,
  input  logic [N_SLOTS-1:0]   hw_iso_fault,
  input  logic [N_SLOTS-1:0]   hw_conn_fault,
  input  logic [N_SLOTS-1:0]   hw_m66,
  input  logic                 upd_valid,
  output logic                 upd_ready,
  input  logic [SLOT_W-1:0]    upd_slot,
  input  logic [1:0]           upd_state,
  input  logic [1:0]           upd_pwr_ind,
  input  logic [1:0]           upd_attn_ind,
  input  logic                 cmd_done,
  input  logic                 arb_fault,
  output logic                 irq,
  output logic                 err_req
);
  localparam int LOC_ADDR   = 0;
  localparam int CTRL_ADDR  = 1;
  localparam int SLOT_BASE  = 2;
  localparam int ARM_CYCLES = 3;
  localparam int ARM_W      = $clog2(ARM_CYCLES + 1);
  localparam int EVT_ALL_W  = NUM_EVT * N_SLOTS;

  logic [ARM_W-1:0]   arm_cnt;
  logic               armed;
  logic [N_SLOTS-1:0] slot_int, slot_err, slot_wr, slot_upd;
  logic [31:0]        slot_rd [N_SLOTS];
  logic [EVT_ALL_W-1:0] evt_all;
  logic [N_SLOTS:0]   locator;
  logic [31:0]        ctrl_rd;
  logic               ctrl_wr, gint_mask, gerr_mask;
  slot_ind_t          upd_ind;

  // detection stays off until synchronizer and edge history hold real levels
  always_ff @(posedge clk) begin
    if (!rst_n)                          arm_cnt <= '0;
    else if (arm_cnt != ARM_W'(ARM_CYCLES)) arm_cnt <= arm_cnt + 1'b1;
  end
  assign armed = arm_cnt == ARM_W'(ARM_CYCLES);

  assign upd_ready = 1'b1;
  assign upd_ind   = '{attn: upd_attn_ind, pwr: upd_pwr_ind, st: upd_state};
  assign ctrl_wr   = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    assign slot_wr[i]  = reg_wr && (reg_addr == ADDR_W'(SLOT_BASE + i));
    assign slot_upd[i] = upd_valid && upd_ready && (upd_slot == SLOT_W'(i));

    hpse_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (armed),
      .hw_prsnt (hw_prsnt[2*i +: 2]),
      .hw_latch (hw_latch_open[i]),
      .hw_btn   (hw_button[i]),
      .hw_iso   (hw_iso_fault[i]),
      .hw_conn  (hw_conn_fault[i]),
      .hw_m66   (hw_m66[i]),
      .wr_hit   (slot_wr[i]),
      .wdata    (reg_wdata[30:16]),
      .upd_hit  (slot_upd[i]),
      .upd_ind  (upd_ind),
      .rdata    (slot_rd[i]),
      .evt_q    (evt_all[NUM_EVT*i +: NUM_EVT]),
      .int_pend (slot_int[i]),
      .err_pend (slot_err[i])
    );
  end

  hpse_ctrl #(.N_SLOTS(N_SLOTS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (ctrl_wr),
    .wmask     (reg_wdata[3:0]),
    .wclr      (reg_wdata[C_ARBF:C_CMDF]),
    .cmd_done  (cmd_done),
    .arb_fault (arb_fault),
    .slot_int  (slot_int),
    .slot_err  (slot_err),
    .locator   (locator),
    .ctrl_rd   (ctrl_rd),
    .irq       (irq),
    .err_req   (err_req),
    .gint_mask (gint_mask),
    .gerr_mask (gerr_mask)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(LOC_ADDR))  reg_rdata = 32'(locator);
    if (reg_addr == ADDR_W'(CTRL_ADDR)) reg_rdata = ctrl_rd;
    for (int i = 0; i < N_SLOTS; i++)
      if (reg_addr == ADDR_W'(SLOT_BASE + i)) reg_rdata = slot_rd[i];
  end
endmodule

// File: rtl/hp_slot_evt_bank_chk.sv
module hp_slot_evt_bank_chk #(
  parameter int N_SLOTS = 4,
  parameter int EVT_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               armed,
  input logic [EVT_W-1:0]   evt_all,
  input logic [N_SLOTS:0]   locator,
  input logic               gint_mask,
  input logic               gerr_mask,
  input logic               reg_wr,
  input logic               irq,
  input logic               err_req
);
  // R12
  quiet_until_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (evt_all == '0));

  // R3
  flag_rise_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_all & ~$past(evt_all)) != '0) |-> $past(armed));

  // R4
  flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~evt_all & $past(evt_all)) != '0) |-> $past(reg_wr));

  // R8
  irq_needs_locator_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locator == '0) |-> !irq);

  // R8
  irq_global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gint_mask |-> !irq);

  // R9
  err_global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gerr_mask |-> !err_req);
endmodule

bind hp_slot_evt_bank hp_slot_evt_bank_chk #(
  .N_SLOTS (N_SLOTS),
  .EVT_W   (EVT_ALL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .armed     (armed),
  .evt_all   (evt_all),
  .locator   (locator),
  .gint_mask (gint_mask),
  .gerr_mask (gerr_mask),
  .reg_wr    (reg_wr),
  .irq       (irq),
  .err_req   (err_req)
);

// File: tb/hp_slot_evt_bank_tb.sv
module hp_slot_evt_bank_tb;
  localparam int N = 4;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_rdata;
  logic [2*N-1:0] hw_prsnt = '1;
  logic [N-1:0] hw_latch_open = '0, hw_button = '0, hw_iso_fault = '0;
  logic [N-1:0] hw_conn_fault = '0, hw_m66 = '0;
  logic upd_valid = 1'b0, upd_ready;
  logic [1:0] upd_slot = '0, upd_state = '0, upd_pwr_ind = '0, upd_attn_ind = '0;
  logic cmd_done = 1'b0, arb_fault = 1'b0;
  logic irq, err_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hp_slot_evt_bank #(.N_SLOTS(N), .ADDR_W(AW)) u_dut (
    .clk, .rst_n, .reg_addr, .reg_wdata, .reg_wr, .reg_rdata,
    .hw_prsnt, .hw_latch_open, .hw_button, .hw_iso_fault, .hw_conn_fault, .hw_m66,
    .upd_valid, .upd_ready, .upd_slot, .upd_state, .upd_pwr_ind, .upd_attn_ind,
    .cmd_done, .arb_fault, .irq, .err_req
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cmd(input bit arb);
    @(negedge clk);
    if (arb) arb_fault = 1'b1; else cmd_done = 1'b1;
    @(negedge clk);
    arb_fault = 1'b0; cmd_done = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2, d); chk("R1 slot0 reset word (R12 no presence event)", d, 32'h7F000C7F);
    rd(5, d); chk("R1 slot3 reset word", d, 32'h7F000C7F);
    rd(1, d); chk("R1 ctrl reset", d, 32'h0000000F);
    rd(0, d); chk("R1 locator reset", d, 32'h0);
    chk("R1 irq low", 32'(irq), 32'h0);
    chk("R1 err low", 32'(err_req), 32'h0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    @(negedge clk);
    hw_button[1] = 1'b1; hw_latch_open[1] = 1'b1; hw_m66[1] = 1'b1;
    hw_prsnt[3:2] = 2'b01; reg_addr = 3;
    @(posedge clk); @(posedge clk); #5;
    chk("R2 levels after two clocks", reg_rdata, 32'h7F0007FF);
    idle(3);
    rd(3, d); chk("R3 presence/button/latch flags", d, 32'h7F0D07FF);
    @(negedge clk); hw_iso_fault[1] = 1'b1;
    idle(4);
    rd(3, d); chk("R2 R3 iso fault status low and flag", d, 32'h7F0F07BF);
    @(negedge clk); hw_conn_fault[1] = 1'b1;
    idle(4);
    rd(3, d); chk("R3 connected fault flag", d, 32'h7F1F07BF);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(3, 32'h7F040000);
    rd(3, d); chk("R4 single W1C", d & 32'h001F0000, 32'h001B0000);
    rd(3, d); wr(3, d);
    rd(3, d); chk("R4 write-back clears all", d & 32'h001F0000, 32'h0);
    @(negedge clk);
    hw_button[1] = 1'b0; hw_iso_fault[1] = 1'b0; hw_conn_fault[1] = 1'b0;
    idle(5);
    rd(3, d); chk("R3 falling edges set nothing", d, 32'h7F00077F);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk); hw_button[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    reg_addr = 4; reg_wdata = 32'h7F040000; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(4, d); chk("R5 event beats same-cycle clear", (d >> 18) & 1, 32'h1);
    @(negedge clk); hw_button[2] = 1'b0;
    idle(4);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(5, 32'hFFFFFFFF);
    rd(5, d); chk("R6 slot reserved bits zero", d & 32'h80E0F000, 32'h0);
    chk("R6 slot full word", d, 32'h7F000C7F);
    wr(1, 32'hFFFFFFFF);
    rd(1, d); chk("R6 ctrl reserved zero", d, 32'h0000000F);
    rd(6, d); chk("R6 unmapped 6", d, 32'h0);
    rd(7, d); chk("R6 unmapped 7", d, 32'h0);
  endtask

  task automatic t_loc_irq;
    logic [31:0] d;
    wr(2, 32'h7B000000);
    wr(1, 32'h0000000E);
    @(negedge clk); hw_button[0] = 1'b1;
    idle(4);
    rd(0, d); chk("R7 slot0 at locator bit1", d, 32'h2);
    chk("R8 irq with unmasked locator", 32'(irq), 32'h1);
    wr(1, 32'h0000000F);
    chk("R8 global mask blocks irq", 32'(irq), 32'h0);
    rd(0, d); chk("R7 locator unaffected by global mask", d, 32'h2);
    wr(1, 32'h0000000E);
    wr(2, 32'h7B040000);
    rd(0, d); chk("R7 locator clears with flag", d, 32'h0);
    chk("R8 irq drops", 32'(irq), 32'h0);
    @(negedge clk); hw_button[0] = 1'b0;
    idle(4);
    wr(1, 32'h0000000A);
    pulse_cmd(1'b0);
    rd(0, d); chk("R7 command at locator bit0", d, 32'h1);
    chk("R8 irq on command", 32'(irq), 32'h1);
    rd(1, d); chk("R11 command flag", d, 32'h0001000A);
    wr(1, 32'h0001000A);
    rd(1, d); chk("R4 ctrl W1C", d, 32'h0000000A);
    wr(5, 32'h7E000000);
    @(negedge clk); hw_prsnt[7:6] = 2'b00;
    idle(5);
    rd(0, d); chk("R7 slot3 at locator bit4", d, 32'h10);
    wr(5, 32'h7E010000);
    rd(0, d); chk("R7 locator cleared", d, 32'h0);
  endtask

  task automatic t_err;
    logic [31:0] d;
    wr(1, 32'h0000000D);
    wr(4, 32'h5F000000);
    @(negedge clk); hw_latch_open[2] = 1'b1;
    idle(5);
    chk("R9 latch change error", 32'(err_req), 32'h1);
    chk("R8 irq masked", 32'(irq), 32'h0);
    wr(4, 32'h5F080000);
    chk("R9 error drops on clear", 32'(err_req), 32'h0);
    wr(1, 32'h00000005);
    pulse_cmd(1'b1);
    chk("R9 arbiter error", 32'(err_req), 32'h1);
    rd(1, d); chk("R11 arbiter flag", d, 32'h00020005);
    wr(1, 32'h00020005);
    chk("R9 arbiter error cleared", 32'(err_req), 32'h0);
  endtask

  task automatic t_ctrl_flags;
    logic [31:0] d;
    wr(1, 32'h0000000F);
    pulse_cmd(1'b0);
    pulse_cmd(1'b1);
    rd(1, d); chk("R11 flags set while masked", d, 32'h0003000F);
    rd(0, d); chk("R7 masked command not in locator", d, 32'h0);
    chk("R8 irq low", 32'(irq), 32'h0);
    wr(1, 32'h0003000F);
  endtask

  task automatic t_update;
    logic [31:0] d;
    chk("R10 ready high", 32'(upd_ready), 32'h1);
    @(negedge clk);
    upd_valid = 1'b1; upd_slot = 2'd1; upd_state = 2'd2; upd_pwr_ind = 2'd2; upd_attn_ind = 2'd1;
    @(negedge clk);
    upd_state = 2'd0; upd_pwr_ind = 2'd1; upd_attn_ind = 2'd0;
    @(negedge clk);
    upd_valid = 1'b0;
    rd(3, d); chk("R10 zero codes keep fields", d & 32'h3F, 32'h16);
    rd(2, d); chk("R10 other slot untouched", d & 32'h3F, 32'h3F);
    wr(3, 32'h7F00003F);
    rd(3, d); chk("R10 software write keeps fields", d & 32'h3F, 32'h16);
  endtask

  initial begin
    idle(4);
    @(negedge clk); rst_n = 1'b1;
    idle(6);
    t_reset();
    t_status();
    t_w1c();
    t_collide();
    t_reserved();
    t_loc_irq();
    t_err();
    t_ctrl_flags();
    t_update();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule